// File: doc/BRIEF.md
# Multi-Format Audio Serial Port Receiver

This block is the receive half of a slave audio serial port. It works entirely in the bit-clock domain. On every rising bit-clock edge it samples the serial data line and the frame clock, and from them it rebuilds a left and a right PCM sample for each frame. Four framings are supported. Two are two-channel framings in which the level of the frame clock marks the channel: a justified framing with no delay and a framing with a one-bit delay. The other two are pulse framings, in which only a rising edge of the frame clock starts a frame and the two channel words follow back to back. A single late-start bit chooses whether a pulse frame's first bit comes on the same edge that sees the rise or on the edge after it.

Words of 16, 20, 24 or 32 bits arrive MSB first. They are placed at the top of 32-bit output registers and the unused low bits are cleared. A strobe one bit clock wide marks each complete frame. A sticky error flag records two faults: a frame edge that cuts a word short, and a frame pulse whose low time before the next rise is too short.

The capture engine is a four-state machine:
- ST_IDLE is the state after reset or after a dropped word.
- ST_ARM waits one edge before an MSB.
- ST_SHIFT collects bits.
- ST_GAP ignores bits that follow a finished word.

Its transitions are as follows:
- start: from ST_IDLE or ST_GAP on a frame edge, into ST_SHIFT if the MSB is sampled on that edge, or into ST_ARM otherwise.
- arm-to-shift: from ST_ARM on the next edge.
- word-done: from ST_SHIFT into ST_GAP.
- chain: from ST_SHIFT into ST_ARM, for the right word of a pulse frame.
- overlap: from ST_SHIFT on a frame edge that coincides with the last bit of a one-bit-delayed word.
- drop: from ST_ARM or ST_SHIFT on an early frame edge, which restarts capture.

Top module: `pcm_serial_rx`

## Requirements
- R1: With `fmt_i` = 2'b00 (justified), the MSB is sampled on the first rising bit-clock edge that sees a new frame-clock level. Frame clock 0 marks the left word and 1 marks the right word.
- R2: With `fmt_i` = 2'b01 (one-bit delay), the MSB is sampled one rising edge later than under R1, and the channel mapping is the same. The last bit of a word may share its edge with the next frame-clock change.
- R3: With `fmt_i` = 2'b10 or 2'b11 (pulse framing), only a rising frame-clock edge starts a frame. The left MSB is sampled on that edge when `late_i` = 0, and on the next edge when `late_i` = 1.
- R4: In pulse framing, the right word's MSB is sampled on the edge directly after the left word's LSB.
- R5: `wlen_i` selects the word length: 00 = 16, 01 = 20, 10 = 24, 11 = 32 bits. A received word is left-aligned in its 32-bit output, and the bits below the word are zero.
- R6: Data-line values on edges after a word's LSB and before the next frame edge do not change the captured words.
- R7: In pulse framing, the width of the frame pulse has no effect on the captured data.
- R8: In pulse framing, a rising frame-clock edge that follows fewer than two sampled low edges sets `frame_err_o`.
- R9: A frame edge that arrives before the current word is complete drops that word, sets `frame_err_o`, and gives no strobe for the broken frame.
- R10: `valid_o` is high for exactly one cycle, in the cycle after the edge that samples the right word's LSB, provided that the left word of the same frame was completed. `left_o` and `right_o` change only together with that strobe.
- R11: A synchronous reset clears the outputs, the error flag and the capture state. After reset, capture starts only at the next frame edge, and `frame_err_o` stays set until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock; all state updates on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| fmt_i | input | 2 | Framing: 00 justified, 01 one-bit delay, 1x pulse |
| late_i | input | 1 | Pulse framing only: 1 puts the left MSB one edge after the rise |
| wlen_i | input | 2 | Word length code (16/20/24/32 bits) |
| ws_i | input | 1 | Frame clock or frame pulse |
| sd_i | input | 1 | Serial data, MSB first |
| left_o | output | 32 | Last complete left sample, left-aligned |
| right_o | output | 32 | Last complete right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe per complete frame |
| frame_err_o | output | 1 | Sticky framing-error flag |

## Verification
The bound checker watches four behaviours on every cycle:
- the strobe lasts exactly one cycle;
- both samples hold their values between strobes;
- the bits below the selected word length are zero;
- the error flag stays set until reset, and reset clears the flag and the strobe.

Some behaviour depends on the bit pattern of a whole frame, and only the directed scenarios can show it:
- where the MSB falls in each framing, and whether `late_i` moves it;
- that the right word chains straight on from the left in pulse framing;
- that stray data after the LSB is ignored;
- that pulse-spacing faults and cut-short words set the flag;
- that no strobe appears after reset until a frame edge has been seen.

// File: rtl/aif_rx_pkg.sv
package aif_rx_pkg;

    localparam int MAX_WORD = 32;
    localparam int LEN_W    = $clog2(MAX_WORD) + 1;

    typedef enum logic [1:0] {
        FMT_JUST    = 2'd0,
        FMT_DELAY   = 2'd1,
        FMT_PULSE   = 2'd2,
        FMT_PULSE_X = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_SHIFT = 2'd2,
        ST_GAP   = 2'd3
    } rx_state_e;

    function automatic logic [LEN_W-1:0] word_bits(input logic [1:0] code);
        logic [LEN_W-1:0] n;
        unique case (code)
            2'd0: n = LEN_W'(16);
            2'd1: n = LEN_W'(20);
            2'd2: n = LEN_W'(24);
            default: n = LEN_W'(32);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/aif_ws_watch.sv
module aif_ws_watch #(
    parameter int RUN_W   = 2,
    parameter int MIN_LOW = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ws_i,
    input  logic pulse_mode_i,
    output logic frame_start_o,
    output logic spacing_bad_o
);

    localparam logic [RUN_W-1:0] RUN_MAX = '1;
    localparam logic [RUN_W-1:0] LOW_MIN = RUN_W'(MIN_LOW);

    logic             ws_q;
    logic             primed;
    logic [RUN_W-1:0] low_run;
    logic             rise;
    logic             change;

    // low_run counts consecutive sampled lows, saturating; it starts full so
    // that the first pulse after reset is never judged too close.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ws_q    <= 1'b0;
            primed  <= 1'b0;
            low_run <= RUN_MAX;
        end else begin
            ws_q   <= ws_i;
            primed <= 1'b1;
            if (ws_i)
                low_run <= '0;
            else if (low_run != RUN_MAX)
                low_run <= low_run + 1'b1;
        end
    end

    always_comb begin
        rise          = primed & ws_i & ~ws_q;
        change        = primed & (ws_i ^ ws_q);
        frame_start_o = pulse_mode_i ? rise : change;
        spacing_bad_o = pulse_mode_i & rise & (low_run < LOW_MIN);
    end

endmodule

// File: rtl/aif_shift_in.sv
module aif_shift_in #(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sd_i,
    output logic [DATA_W-1:0] word_raw_o
);

    logic [DATA_W-2:0] sh;

    // Shifts on every edge; a finished word is simply the newest bits.
    assign word_raw_o = {sh, sd_i};

    always_ff @(posedge clk_i) begin
        if (rst_i)
            sh <= '0;
        else
            sh <= word_raw_o[DATA_W-2:0];
    end

endmodule

// File: rtl/aif_left_align.sv
module aif_left_align #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic [DATA_W-1:0] raw_i,
    input  logic [CNT_W-1:0]  nbits_i,
    output logic [DATA_W-1:0] aligned_o
);

    logic [CNT_W-1:0] amt;

    always_comb begin
        amt       = CNT_W'(DATA_W) - nbits_i;
        aligned_o = raw_i << amt;
    end

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
    import aif_rx_pkg::*;
#(
    parameter int DATA_W = MAX_WORD
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [1:0]        fmt_i,
    input  logic              late_i,
    input  logic [1:0]        wlen_i,
    input  logic              ws_i,
    input  logic              sd_i,
    output logic [DATA_W-1:0] left_o,
    output logic [DATA_W-1:0] right_o,
    output logic              valid_o,
    output logic              frame_err_o
);

    localparam int CNT_W = $clog2(DATA_W) + 1;

    rx_state_e         state, nxt_state;
    logic [CNT_W-1:0]  cnt, nxt_cnt;
    logic              ch, nxt_ch;
    logic [CNT_W-1:0]  nbits;
    logic              pulse_mode;
    logic              lead;
    logic              start_ch;
    logic              frame_start;
    logic              spacing_bad;
    logic              word_done;
    logic              drop;
    logic              go;
    logic [DATA_W-1:0] word_raw;
    logic [DATA_W-1:0] aligned;
    logic [DATA_W-1:0] left_hold;
    logic              left_done;
    fmt_e              fmt;

    assign fmt        = fmt_e'(fmt_i);
    assign pulse_mode = (fmt == FMT_PULSE) || (fmt == FMT_PULSE_X);
    assign nbits      = CNT_W'(word_bits(wlen_i));
    // lead: the edge that sees the frame edge also carries the MSB
    assign lead       = (fmt == FMT_JUST) || (pulse_mode && !late_i);
    assign start_ch   = pulse_mode ? 1'b0 : ws_i;

    aif_ws_watch #(
        .RUN_W   (2),
        .MIN_LOW (2)
    ) u_watch (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .ws_i          (ws_i),
        .pulse_mode_i  (pulse_mode),
        .frame_start_o (frame_start),
        .spacing_bad_o (spacing_bad)
    );

    aif_shift_in #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .sd_i       (sd_i),
        .word_raw_o (word_raw)
    );

    aif_left_align #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_align (
        .raw_i     (word_raw),
        .nbits_i   (nbits),
        .aligned_o (aligned)
    );

    // Next-state logic
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        nxt_ch    = ch;
        word_done = 1'b0;
        drop      = 1'b0;
        go        = 1'b0;
        unique case (state)
            ST_IDLE, ST_GAP: begin
                if (frame_start) go = 1'b1;
            end
            ST_ARM: begin
                if (frame_start) begin
                    drop = 1'b1;
                    go   = 1'b1;
                end else begin
                    nxt_state = ST_SHIFT;
                    nxt_cnt   = nbits - CNT_W'(2);
                end
            end
            ST_SHIFT: begin
                if (cnt == '0) begin
                    if (frame_start && lead) begin
                        drop = 1'b1;
                        go   = 1'b1;
                    end else begin
                        word_done = 1'b1;
                        if (frame_start) begin
                            go = 1'b1;
                        end else if (pulse_mode && !ch) begin
                            nxt_state = ST_ARM;
                            nxt_ch    = 1'b1;
                        end else begin
                            nxt_state = ST_GAP;
                        end
                    end
                end else if (frame_start) begin
                    drop = 1'b1;
                    go   = 1'b1;
                end else begin
                    nxt_cnt = cnt - 1'b1;
                end
            end
        endcase
        if (go) begin
            nxt_ch = start_ch;
            if (lead) begin
                nxt_state = ST_SHIFT;
                nxt_cnt   = nbits - CNT_W'(2);
            end else begin
                nxt_state = ST_ARM;
            end
        end
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ch    <= 1'b0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
            ch    <= nxt_ch;
        end
    end

    // Outputs
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            left_o      <= '0;
            right_o     <= '0;
            left_hold   <= '0;
            left_done   <= 1'b0;
            valid_o     <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (drop || spacing_bad)
                frame_err_o <= 1'b1;
            if (drop)
                left_done <= 1'b0;
            if (word_done) begin
                if (!ch) begin
                    left_hold <= aligned;
                    left_done <= 1'b1;
                end else begin
                    if (left_done) begin
                        left_o  <= left_hold;
                        right_o <= aligned;
                        valid_o <= 1'b1;
                    end
                    left_done <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/pcm_serial_rx_chk.sv
module pcm_serial_rx_chk
    import aif_rx_pkg::*;
(
    input logic        clk_i,
    input logic        rst_i,
    input logic [1:0]  wlen_i,
    input logic [31:0] left_o,
    input logic [31:0] right_o,
    input logic        valid_o,
    input logic        frame_err_o
);

    logic [31:0] low_mask;

    always_comb low_mask = ~(32'hFFFF_FFFF << (6'd32 - 6'(word_bits(wlen_i))));

    // R10
    single_strobe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> !valid_o);

    // R10
    hold_left_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_o |-> $stable(left_o));

    // R10
    hold_right_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_o |-> $stable(right_o));

    // R5
    low_bits_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> ((left_o & low_mask) == 32'd0 && (right_o & low_mask) == 32'd0));

    // R11
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_err_o |=> frame_err_o);

    // R11
    reset_clear_chk: assert property (@(posedge clk_i)
        rst_i |=> (!frame_err_o && !valid_o));

endmodule

bind pcm_serial_rx pcm_serial_rx_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wlen_i      (wlen_i),
    .left_o      (left_o),
    .right_o     (right_o),
    .valid_o     (valid_o),
    .frame_err_o (frame_err_o)
);

// File: tb/tb_pcm_serial_rx.sv
module tb_pcm_serial_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  fmt = 2'd0;
    logic [1:0]  wlen = 2'd0;
    logic        late = 1'b0;
    logic        ws = 1'b0;
    logic        sd = 1'b0;
    logic [31:0] left, right;
    logic        valid, err;

    always #5 clk = ~clk;

    pcm_serial_rx dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .fmt_i       (fmt),
        .late_i      (late),
        .wlen_i      (wlen),
        .ws_i        (ws),
        .sd_i        (sd),
        .left_o      (left),
        .right_o     (right),
        .valid_o     (valid),
        .frame_err_o (err)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic        ws_a [0:4095];
    logic        sd_a [0:4095];
    int          len;
    logic [31:0] got_l [0:15];
    logic [31:0] got_r [0:15];
    int          got_n = 0;
    logic [31:0] exp_l [0:15];
    logic [31:0] exp_r [0:15];
    int          exp_n;

    always @(negedge clk) begin
        if (!rst && valid) begin
            if (got_n < 16) begin
                got_l[got_n] = left;
                got_r[got_n] = right;
            end
            got_n = got_n + 1;
        end
    end

    function automatic logic [31:0] keep(input int nb);
        return 32'hFFFF_FFFF << (32 - nb);
    endfunction

    function automatic logic [31:0] pat(input int i, input int side);
        return (32'h9E37_79B9 * (i + 3)) ^ (side ? 32'h5A5A_C3C3 : 32'h0F1E_2D3C);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic clear_stream();
        len = 0;
        exp_n = 0;
        for (int i = 0; i < 4096; i++) begin
            ws_a[i] = 1'b0;
            sd_a[i] = 1'b1;
        end
    endtask

    task automatic add_slots(input logic w, input int n);
        for (int i = 0; i < n; i++) ws_a[len + i] = w;
        len += n;
    endtask

    task automatic add_lr(input int off, input int nb, input int slots,
                          input logic [31:0] l, input logic [31:0] r);
        int base;
        base = len;
        add_slots(1'b0, slots);
        add_slots(1'b1, slots);
        for (int k = 0; k < nb; k++) begin
            sd_a[base + off + k]         = l[31 - k];
            sd_a[base + slots + off + k] = r[31 - k];
        end
    endtask

    task automatic add_pulse(input int off, input int nb, input int frame, input int pw,
                             input logic [31:0] l, input logic [31:0] r);
        int base;
        base = len;
        add_slots(1'b1, pw);
        add_slots(1'b0, frame - pw);
        for (int k = 0; k < nb; k++) begin
            sd_a[base + off + k]      = l[31 - k];
            sd_a[base + off + nb + k] = r[31 - k];
        end
    endtask

    task automatic play();
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            ws = ws_a[i];
            sd = sd_a[i];
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] f, input logic lt, input logic [1:0] wl,
                            input logic w);
        @(negedge clk);
        rst  = 1'b1;
        fmt  = f;
        late = lt;
        wlen = wl;
        ws   = w;
        sd   = 1'b0;
        repeat (3) @(negedge clk);
        got_n = 0;
        rst   = 1'b0;
    endtask

    task automatic compare(input string tag, input logic exp_err);
        check(got_n == exp_n, {tag, " frame count"}, 32'(got_n), 32'(exp_n));
        check(err == exp_err, {tag, " error flag"}, 32'(err), 32'(exp_err));
        for (int i = 0; i < exp_n && i < 16; i++) begin
            check(got_l[i] === exp_l[i], {tag, " left word"}, got_l[i], exp_l[i]);
            check(got_r[i] === exp_r[i], {tag, " right word"}, got_r[i], exp_r[i]);
        end
    endtask

    task automatic lr_case(input string tag, input int off, input logic [1:0] wl,
                           input int nb, input int slots, input int frames);
        do_reset(off[0] ? 2'd1 : 2'd0, 1'b0, wl, 1'b1);
        clear_stream();
        add_slots(1'b1, 3);
        for (int i = 0; i < frames; i++) begin
            add_lr(off, nb, slots, pat(i, 0), pat(i, 1));
            exp_l[i] = pat(i, 0) & keep(nb);
            exp_r[i] = pat(i, 1) & keep(nb);
        end
        exp_n = frames;
        add_slots(1'b1, 4);
        play();
        compare(tag, 1'b0);
    endtask

    task automatic pulse_case(input string tag, input logic lt, input logic [1:0] wl,
                              input int nb, input int frame, input int pw,
                              input int frames, input logic exp_err);
        do_reset(2'd2, lt, wl, 1'b0);
        clear_stream();
        add_slots(1'b0, 4);
        for (int i = 0; i < frames; i++) begin
            add_pulse(lt ? 1 : 0, nb, frame, pw, pat(i + 7, 0), pat(i + 7, 1));
            exp_l[i] = pat(i + 7, 0) & keep(nb);
            exp_r[i] = pat(i + 7, 1) & keep(nb);
        end
        exp_n = frames;
        add_slots(1'b0, 4);
        play();
        compare(tag, exp_err);
    endtask

    // R11: reset state
    task automatic t_reset();
        do_reset(2'd0, 1'b0, 2'd0, 1'b1);
        @(negedge clk);
        check(left == 32'd0, "R11 reset left", left, 32'd0);
        check(right == 32'd0, "R11 reset right", right, 32'd0);
        check(valid == 1'b0, "R11 reset strobe", 32'(valid), 32'd0);
        check(err == 1'b0, "R11 reset error", 32'(err), 32'd0);
    endtask

    // R1 R5 R6 R10: justified, 24-bit words in 32 slots, gap filled with ones
    task automatic t_just24();
        lr_case("R1 R5 R6 R10 justified 24b", 0, 2'd2, 24, 32, 3);
    endtask

    // R1 R5: justified, 32-bit words filling every slot
    task automatic t_just32();
        lr_case("R1 R5 justified 32b", 0, 2'd3, 32, 32, 2);
    endtask

    // R2: one-bit delay, 16-bit words with LSB on the frame-clock change
    task automatic t_delay16();
        lr_case("R2 delayed 16b tight", 1, 2'd0, 16, 16, 3);
    endtask

    // R2 R6: one-bit delay, 20-bit words with spare slots
    task automatic t_delay20();
        lr_case("R2 R6 delayed 20b", 1, 2'd1, 20, 24, 2);
    endtask

    // R3 R4 R7: pulse framing, MSB on the rise edge, one-slot pulse
    task automatic t_pulse_early();
        pulse_case("R3 R4 R7 pulse early 32b", 1'b0, 2'd3, 32, 70, 1, 2, 1'b0);
    endtask

    // R3 R4 R7 R6: pulse framing, MSB one edge late, pulse wider than a word
    task automatic t_pulse_late();
        pulse_case("R3 R4 R7 pulse late 16b", 1'b1, 2'd0, 16, 40, 20, 3, 1'b0);
    endtask

    // R8: low time of one slot before the next rise
    task automatic t_spacing();
        pulse_case("R8 pulse spacing", 1'b0, 2'd0, 16, 36, 35, 2, 1'b1);
    endtask

    // R9: left word cut short by the frame-clock change
    task automatic t_partial();
        do_reset(2'd0, 1'b0, 2'd0, 1'b1);
        clear_stream();
        add_slots(1'b1, 3);
        add_slots(1'b0, 10);
        add_lr(0, 16, 16, pat(20, 0), pat(20, 1));
        len -= 32;
        for (int i = 0; i < 16; i++) ws_a[len + i] = 1'b1;
        for (int k = 0; k < 16; k++) sd_a[len + k] = pat(21, 1)[31 - k];
        len += 16;
        add_lr(0, 16, 16, pat(22, 0), pat(22, 1));
        exp_l[0] = pat(22, 0) & keep(16);
        exp_r[0] = pat(22, 1) & keep(16);
        exp_n = 1;
        add_slots(1'b1, 4);
        play();
        compare("R9 cut-short word", 1'b1);
    endtask

    // R11: after reset nothing is captured until a frame edge is seen
    task automatic t_restart();
        do_reset(2'd0, 1'b0, 2'd0, 1'b0);
        clear_stream();
        add_slots(1'b0, 16);
        add_slots(1'b1, 16);
        for (int k = 0; k < 16; k++) sd_a[16 + k] = pat(30, 1)[31 - k];
        add_lr(0, 16, 16, pat(31, 0), pat(31, 1));
        exp_l[0] = pat(31, 0) & keep(16);
        exp_r[0] = pat(31, 1) & keep(16);
        exp_n = 1;
        add_slots(1'b1, 4);
        play();
        compare("R11 wait for edge", 1'b0);
        check(left == exp_l[0], "R10 R11 held left", left, exp_l[0]);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_just24();
        t_just32();
        t_delay16();
        t_delay20();
        t_pulse_early();
        t_pulse_late();
        t_spacing();
        t_partial();
        t_restart();
        summary();
        $finish;
    end

endmodule